// File: doc/BRIEF.md
# Shadow Stack Pointer Register

This block holds the shadow stack pointer as a user-accessible control and status register at address 0x011. Each cycle it can take one access request. The request carries a write flag, the target address, the write value, the hart's current privilege mode, the current XLEN (32 or 64 bits) and three effective shadow-stack enables: machine level, hypervisor level and supervisor level. One cycle later the block answers with either the masked register contents or an exception code.

The enables form a chain that depends on both privilege and virtualisation. A failure at the machine level, or at the supervisor level for a non-virtual user access, gives an illegal-instruction code. A failure that only the hypervisor-level or supervisor-level enable causes for a virtualised mode gives a virtual-instruction code. Machine mode always passes.

The two lowest bits never hold ones. With a 64-bit XLEN, bit 2 reads as zero as well. The block does not deliver the exception, and it does not do the pointer arithmetic of push and pop.

Top module: `shstk_ptr_csr`

## Requirements
- R1: A response (`rsp_valid`=1) appears exactly one cycle after a request with `req_valid`=1 and `req_addr`=0x011, and at no other time.
- R2: Synchronous reset (`rst`=1) clears the stored pointer to 0 and drops `rsp_valid`.
- R3: `rsp_exc`=1 (illegal) is returned for an access from S (`req_priv`=3'b001), U (3'b000), VS (3'b101) or VU (3'b100) while `en_machine`=0. It is also returned from U while `en_super`=0, and from any undefined `req_priv` encoding.
- R4: When R3 does not apply, `rsp_exc`=2 (virtual) is returned from VS while `en_hyper`=0, and from VU while `en_hyper`=0 or `en_super`=0.
- R5: Machine mode (`req_priv`=3'b011) always gets `rsp_exc`=0, whatever the enables.
- R6: A successful access with `req_xlen64`=1 returns the stored pointer with bits 2:0 cleared.
- R7: A successful access with `req_xlen64`=0 returns stored bits 31:2, with bits 1:0 and 63:32 as zero.
- R8: A successful write stores the write value masked as in R6 or R7 for the request's XLEN; a 32-bit write zero-extends. The response carries the value held before the write.
- R9: A faulting access returns `rsp_rdata`=0 and leaves the stored pointer unchanged.
- R10: A request to any other address gives no response and does not change the stored pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | Request also writes `req_wdata` |
| req_addr | input | 12 | Register address of the request |
| req_wdata | input | 64 | Write value |
| req_priv | input | 3 | Mode: {virtual, level}; U=000, S=001, M=011, VU=100, VS=101 |
| req_xlen64 | input | 1 | 1 when the current XLEN is 64, 0 when it is 32 |
| en_machine | input | 1 | Machine-level shadow-stack enable |
| en_hyper | input | 1 | Hypervisor-level shadow-stack enable |
| en_super | input | 1 | Supervisor-level shadow-stack enable |
| rsp_valid | output | 1 | Response strobe, one cycle after an addressed request |
| rsp_exc | output | 2 | 0 none, 1 illegal-instruction, 2 virtual-instruction |
| rsp_rdata | output | 64 | Masked pointer value held before the access, 0 on a fault |

## Verification
Two things can fall in the same cycle: the enable-chain decision, and the write that it either permits or blocks. Every write in the sweep also reads back the old value. The sweep drives writes with distinct patterns across all five modes, all eight enable combinations and both XLEN settings. The response is judged on the exception code and on the old value returned. A follow-up machine-mode read then shows whether the store changed, which separates a blocked write from one that was only reported as blocked.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int unsigned DATA_W   = 64;
    localparam int unsigned HALF_W   = 32;
    localparam int unsigned ADDR_W   = 12;
    localparam logic [ADDR_W-1:0] SSP_ADDR = 12'h011;
    localparam int unsigned WIDE_LSB = 3;
    localparam int unsigned NARR_LSB = 2;

    typedef enum logic [2:0] {
        PRIV_U  = 3'b000,
        PRIV_S  = 3'b001,
        PRIV_M  = 3'b011,
        PRIV_VU = 3'b100,
        PRIV_VS = 3'b101
    } priv_e;

    typedef enum logic [1:0] {
        EXC_NONE    = 2'd0,
        EXC_ILLEGAL = 2'd1,
        EXC_VIRTUAL = 2'd2
    } exc_e;

    typedef struct packed {
        logic m_en;
        logic h_en;
        logic s_en;
    } enables_t;

    typedef struct packed {
        logic              valid;
        exc_e              exc;
        logic [DATA_W-1:0] data;
    } rsp_t;

    // View of a pointer value legal under the given XLEN
    function automatic logic [DATA_W-1:0] legal_view(input logic [DATA_W-1:0] v,
                                                     input logic wide);
        logic [DATA_W-1:0] r;
        r = '0;
        if (wide) begin
            r[DATA_W-1:WIDE_LSB] = v[DATA_W-1:WIDE_LSB];
        end else begin
            r[HALF_W-1:NARR_LSB] = v[HALF_W-1:NARR_LSB];
        end
        return r;
    endfunction

endpackage

// File: rtl/ssp_access_gate.sv
module ssp_access_gate
    import ssp_pkg::*;
(
    input  priv_e    priv,
    input  enables_t en,
    output exc_e     exc
);
    always_comb begin
        exc = EXC_NONE;
        case (priv)
            PRIV_M:  exc = EXC_NONE;
            PRIV_S:  if (!en.m_en) exc = EXC_ILLEGAL;
            PRIV_U:  if (!en.m_en || !en.s_en) exc = EXC_ILLEGAL;
            PRIV_VS: begin
                if (!en.m_en)      exc = EXC_ILLEGAL;
                else if (!en.h_en) exc = EXC_VIRTUAL;
            end
            PRIV_VU: begin
                if (!en.m_en)                    exc = EXC_ILLEGAL;
                else if (!en.h_en || !en.s_en)   exc = EXC_VIRTUAL;
            end
            default: exc = EXC_ILLEGAL;
        endcase
    end
endmodule

// File: rtl/ssp_store.sv
module ssp_store
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              wide,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= legal_view(wdata, wide);
        end
    end
endmodule

// File: rtl/ssp_resp_reg.sv
module ssp_resp_reg
    import ssp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  rsp_t d,
    output rsp_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{valid: 1'b0, exc: EXC_NONE, data: '0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/shstk_ptr_csr.sv
module shstk_ptr_csr
    import ssp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [11:0] req_addr,
    input  logic [63:0] req_wdata,
    input  logic [2:0]  req_priv,
    input  logic        req_xlen64,
    input  logic        en_machine,
    input  logic        en_hyper,
    input  logic        en_super,
    output logic        rsp_valid,
    output logic [1:0]  rsp_exc,
    output logic [63:0] rsp_rdata
);
    logic              hit;
    exc_e              exc_c;
    enables_t          en_c;
    logic              do_write;
    logic [DATA_W-1:0] store_q;
    rsp_t              rsp_d;
    rsp_t              rsp_q;

    assign hit  = req_valid && (req_addr == SSP_ADDR);
    assign en_c = '{m_en: en_machine, h_en: en_hyper, s_en: en_super};

    ssp_access_gate u_gate (
        .priv (priv_e'(req_priv)),
        .en   (en_c),
        .exc  (exc_c)
    );

    assign do_write = hit && req_write && (exc_c == EXC_NONE);

    ssp_store u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (do_write),
        .wide  (req_xlen64),
        .wdata (req_wdata),
        .q     (store_q)
    );

    always_comb begin
        rsp_d.valid = hit;
        rsp_d.exc   = hit ? exc_c : EXC_NONE;
        rsp_d.data  = (hit && exc_c == EXC_NONE) ? legal_view(store_q, req_xlen64) : '0;
    end

    ssp_resp_reg u_resp (
        .clk (clk),
        .rst (rst),
        .d   (rsp_d),
        .q   (rsp_q)
    );

    assign rsp_valid = rsp_q.valid;
    assign rsp_exc   = rsp_q.exc;
    assign rsp_rdata = rsp_q.data;
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [11:0] req_addr,
    input logic [2:0]  req_priv,
    input logic        req_xlen64,
    input logic        rsp_valid,
    input logic [1:0]  rsp_exc,
    input logic [63:0] rsp_rdata,
    input logic [63:0] store_q
);
    logic hit;
    assign hit = req_valid && (req_addr == 12'h011);

    // R1
    rsp_only_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(hit));

    // R1
    hit_gives_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> rsp_valid);

    // R5
    machine_never_faults_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && req_priv == 3'b011) |=> (rsp_exc == 2'd0));

    // R6
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_rdata[1:0] == 2'b00));

    // R7
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !req_xlen64) |=> (rsp_rdata[63:32] == 32'h0));

    // R9
    fault_keeps_store_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_exc != 2'd0) |-> $stable(store_q));

    // R9
    fault_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_exc != 2'd0) |-> (rsp_rdata == 64'h0));

    // R10
    miss_keeps_store_chk: assert property (@(posedge clk) disable iff (rst)
        (!hit || !req_write) |=> $stable(store_q));
endmodule

bind shstk_ptr_csr ssp_chk u_ssp_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_priv   (req_priv),
    .req_xlen64 (req_xlen64),
    .rsp_valid  (rsp_valid),
    .rsp_exc    (rsp_exc),
    .rsp_rdata  (rsp_rdata),
    .store_q    (store_q)
);

// File: tb/shstk_ptr_csr_bench.sv
module shstk_ptr_csr_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_xlen64;
    logic [11:0] req_addr;
    logic [63:0] req_wdata;
    logic [2:0]  req_priv;
    logic        en_machine, en_hyper, en_super;
    logic        rsp_valid;
    logic [1:0]  rsp_exc;
    logic [63:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [63:0] model;

    always #10 clk = ~clk;

    shstk_ptr_csr u_shstk_ptr_csr (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_priv(req_priv),
        .req_xlen64(req_xlen64), .en_machine(en_machine), .en_hyper(en_hyper),
        .en_super(en_super), .rsp_valid(rsp_valid), .rsp_exc(rsp_exc),
        .rsp_rdata(rsp_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] view(input logic [63:0] v, input bit wide);
        if (wide) return (v >> 3) << 3;
        return ((v & 64'hFFFF_FFFF) >> 2) << 2;
    endfunction

    // 0 none, 1 illegal, 2 virtual
    function automatic logic [1:0] exp_exc(input logic [2:0] p, input bit m, input bit h,
                                           input bit s);
        if (p == 3'b011) return 2'd0;
        if (p != 3'b000 && p != 3'b001 && p != 3'b100 && p != 3'b101) return 2'd1;
        if (!m) return 2'd1;
        if (p == 3'b000 && !s) return 2'd1;
        if (p == 3'b101 && !h) return 2'd2;
        if (p == 3'b100 && (!h || !s)) return 2'd2;
        return 2'd0;
    endfunction

    task automatic access(input logic [2:0] p, input bit wr, input bit wide,
                          input logic [2:0] en, input logic [11:0] a,
                          input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_xlen64 = wide; req_priv = p;
        req_addr = a; req_wdata = wd;
        {en_machine, en_hyper, en_super} = en;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic m_read_check(input string req);
        access(3'b011, 1'b0, 1'b1, 3'b111, 12'h011, 64'h0);
        check(rsp_valid && rsp_exc == 2'd0 && rsp_rdata == view(model, 1'b1), req,
              rsp_rdata, view(model, 1'b1));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [2:0] privs [5];
        privs = '{3'b000, 3'b001, 3'b011, 3'b100, 3'b101};
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_xlen64 = 1'b1;
        req_addr = '0; req_wdata = '0; req_priv = 3'b011;
        en_machine = 1'b0; en_hyper = 1'b0; en_super = 1'b0;
        model = 64'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2: reset state
        check(rsp_valid == 1'b0, "R2 rsp_valid after reset", {63'h0, rsp_valid}, 64'h0);
        m_read_check("R2 pointer zero after reset");

        // R3 R4 R5 R6 R7 R8 R9: full sweep of modes, enables and XLEN
        for (int pi = 0; pi < 5; pi++) begin
            for (int e = 0; e < 8; e++) begin
                for (int x = 0; x < 2; x++) begin
                    logic [63:0] wd;
                    logic [1:0]  xe;
                    logic [63:0] xd;
                    wd = {32'hC3A5_9E1F ^ 32'(pi * 8 + e), 32'h7B96_D2E7 + 32'(x * 4 + e)};
                    xe = exp_exc(privs[pi], e[2], e[1], e[0]);
                    xd = (xe == 2'd0) ? view(model, x[0]) : 64'h0;
                    access(privs[pi], 1'b1, x[0], e[2:0], 12'h011, wd);
                    check(rsp_valid && rsp_exc == xe,
                          (xe == 2'd1) ? "R3 illegal code" :
                          (xe == 2'd2) ? "R4 virtual code" : "R5 no fault code",
                          {62'h0, rsp_exc}, {62'h0, xe});
                    check(rsp_rdata == xd,
                          (xe != 2'd0) ? "R9 fault data zero" :
                          (x != 0) ? "R6 wide old value" : "R7 narrow old value",
                          rsp_rdata, xd);
                    if (xe == 2'd0) model = view(wd, x[0]);
                    m_read_check((xe == 2'd0) ? "R8 stored after write" : "R9 store unchanged");
                end
            end
        end

        // R3: undefined mode encoding with all enables set
        access(3'b010, 1'b1, 1'b1, 3'b111, 12'h011, 64'h1234_5678_9ABC_DEF0);
        check(rsp_exc == 2'd1, "R3 undefined mode illegal", {62'h0, rsp_exc}, 64'h1);
        m_read_check("R9 undefined mode store unchanged");

        // R7 R8: narrow write of all ones zero-extends and clears bits 1:0
        access(3'b011, 1'b1, 1'b0, 3'b000, 12'h011, 64'hFFFF_FFFF_FFFF_FFFF);
        model = 64'h0000_0000_FFFF_FFFC;
        access(3'b011, 1'b0, 1'b0, 3'b000, 12'h011, 64'h0);
        check(rsp_rdata == 64'h0000_0000_FFFF_FFFC, "R7 narrow read", rsp_rdata,
              64'h0000_0000_FFFF_FFFC);
        m_read_check("R8 narrow write seen wide");

        // R6: wide write of all ones
        access(3'b011, 1'b1, 1'b1, 3'b000, 12'h011, 64'hFFFF_FFFF_FFFF_FFFF);
        model = 64'hFFFF_FFFF_FFFF_FFF8;
        m_read_check("R6 wide bits 2:0 clear");

        // R10: other address
        access(3'b011, 1'b1, 1'b1, 3'b111, 12'h012, 64'h0);
        check(rsp_valid == 1'b0, "R10 no response on miss", {63'h0, rsp_valid}, 64'h0);
        m_read_check("R10 store unchanged on miss");

        // R1: idle cycle gives no response
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 idle no response", {63'h0, rsp_valid}, 64'h0);

        // R2: reset mid-run clears pointer
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model = 64'h0;
        m_read_check("R2 pointer cleared by reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule